// File: doc/BRIEF.md
# Resync-Masked Error-Rate Interval Accumulator

This block sits behind a bit-error detector and turns its per-cycle error and compared-bit increments into long-running totals. Counting runs in fixed measurement windows whose length is a programmable number of clock cycles. When a window ends with an error ratio at or above a programmable trigger, the detector is assumed to have slipped out of pattern lock. That window's burst is then not allowed to reach the totals.

Every finished window first waits in a one-deep holding stage, so the totals trail the input by one window. If the next window trips the trigger, the held window is checked against an error threshold: a clean one is committed and a suspect one is dropped. Accumulation then stops until the detector reports lock again. With masking enabled, one synthetic bit and, by option, one synthetic error stand in for the discarded burst. The synthetic error is never charged to the errored-zeros or errored-ones totals. A resync counter records every event, whether masking is on or off.

The error ratio is tested without a divider. A window trips when its error count shifted left by a programmable amount reaches its compared-bit count.

Top module: `ber_resync_accum`

## Requirements
- R1: A finished window whose trigger does not fire is held back and reaches the totals only when the next window ends. Totals change only on window-end cycles or on clear.
- R2: A window trips when its bit count is non-zero and (errors << ratio_k) >= bits. With mask_en=1 its own counts never reach the totals.
- R3: On a tripped window with mask_en=1, the held window is committed if its error count (zeros plus ones) is at most prev_thresh and discarded if it is larger.
- R4: After a trip, increments are ignored and the totals hold until a cycle with sync_ok=1. The next window starts counting on the following cycle.
- R5: resync_cnt increases by exactly one per trip, with mask_en either 0 or 1.
- R6: With mask_en=1, each trip adds 1 to tot_bits and adds 1 to tot_err when one_err_opt=1, or 0 when one_err_opt=0.
- R7: The synthetic error never changes tot_zero_err or tot_one_err. tot_err is the sum of both plus synthetic errors.
- R8: With mask_en=0, a trip commits the held window and the tripped window in full, and the block still pauses for sync.
- R9: Every total saturates at its all-ones value instead of wrapping.
- R10: clr=1 zeroes all totals and resync_cnt, drops the held window and starts a fresh window on the next cycle.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of totals, holding stage and window |
| mask_en | input | 1 | 1: discard tripped bursts and add synthetic counts |
| one_err_opt | input | 1 | 1: synthetic error is one; 0: zero |
| ivl_len | input | IVL_W | Window length in cycles (at least 1) |
| ratio_k | input | KSH_W | Trigger shift: trip when errors*2^k >= bits |
| prev_thresh | input | IVL_W+INC_W+1 | Held-window error limit |
| sync_ok | input | 1 | Detector reports pattern lock |
| zero_err_inc | input | INC_W | Errored zeros this cycle |
| one_err_inc | input | INC_W | Errored ones this cycle |
| bit_inc | input | INC_W | Compared bits this cycle |
| tot_err | output | CNT_W | Total errors |
| tot_bits | output | CNT_W | Total compared bits |
| tot_zero_err | output | CNT_W | Total errored zeros |
| tot_one_err | output | CNT_W | Total errored ones |
| resync_cnt | output | RS_W | Resync event count |

## Verification
A held window that is lost or duplicated shows up as a tot_bits step of the wrong size one window after it was fed in. A wrong trip decision shows on the same window-end edge: resync_cnt fails to step, or the synthetic bit is missing. A pause state that never ends leaves the totals frozen for the whole next window. A mis-routed synthetic error breaks the sum of errored zeros and errored ones against tot_err immediately. Each scenario checks the totals one negative edge after the window-end edge it depends on.

// File: rtl/ber_rsm_pkg.sv
package ber_rsm_pkg;
   typedef enum logic {
      ST_RUN   = 1'b0,
      ST_PAUSE = 1'b1
   } rsm_state_e;
endpackage

// File: rtl/ber_sat_ctr.sv
module ber_sat_ctr #(
   parameter int CNT_W = 48,
   parameter int ADD_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [ADD_W-1:0] add,
   output logic [CNT_W-1:0] q
);
   localparam int SW = ((ADD_W > CNT_W) ? ADD_W : CNT_W) + 1;
   localparam logic [SW-1:0] MAXV = SW'({CNT_W{1'b1}});

   logic [SW-1:0] sum;
   assign sum = SW'(q) + SW'(add);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= '0;
      else if (clr)        q <= '0;
      else if (sum > MAXV) q <= '1;
      else                 q <= sum[CNT_W-1:0];
   end
endmodule

// File: rtl/ber_ivl_acc.sv
module ber_ivl_acc #(
   parameter int INC_W = 8,
   parameter int IVL_W = 16,
   parameter int ACC_W = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [IVL_W-1:0] ivl_len,
   input  logic [INC_W-1:0] e0_inc,
   input  logic [INC_W-1:0] e1_inc,
   input  logic [INC_W-1:0] b_inc,
   output logic             last,
   output logic [ACC_W-1:0] fin_e0,
   output logic [ACC_W-1:0] fin_e1,
   output logic [ACC_W-1:0] fin_b
);
   logic [IVL_W-1:0] tick;
   logic [ACC_W-1:0] cur_e0, cur_e1, cur_b;

   assign last   = run && (tick == IVL_W'(ivl_len - 1'b1));
   assign fin_e0 = cur_e0 + ACC_W'(e0_inc);
   assign fin_e1 = cur_e1 + ACC_W'(e1_inc);
   assign fin_b  = cur_b  + ACC_W'(b_inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick   <= '0;
         cur_e0 <= '0;
         cur_e1 <= '0;
         cur_b  <= '0;
      end else if (restart || !run || last) begin
         tick   <= '0;
         cur_e0 <= '0;
         cur_e1 <= '0;
         cur_b  <= '0;
      end else begin
         tick   <= tick + 1'b1;
         cur_e0 <= fin_e0;
         cur_e1 <= fin_e1;
         cur_b  <= fin_b;
      end
   end
endmodule

// File: rtl/ber_ratio_trip.sv
module ber_ratio_trip #(
   parameter int ACC_W       = 25,
   parameter int KSH_W       = 5,
   parameter bit TRIG_STRICT = 1'b0
) (
   input  logic [ACC_W:0]   err,
   input  logic [ACC_W-1:0] bits,
   input  logic [KSH_W-1:0] k,
   output logic             hit
);
   localparam int SHW = ACC_W + 1 + (2 ** KSH_W) - 1;

   logic [SHW-1:0] err_sh;
   logic [SHW-1:0] bits_w;
   logic           cmp;

   assign err_sh = SHW'(err) << k;
   assign bits_w = SHW'(bits);

   generate
      if (TRIG_STRICT) begin : g_strict
         assign cmp = err_sh > bits_w;
      end else begin : g_reach
         assign cmp = err_sh >= bits_w;
      end
   endgenerate

   assign hit = (bits != '0) && cmp;
endmodule

// File: rtl/ber_resync_accum.sv
module ber_resync_accum
   import ber_rsm_pkg::*;
#(
   parameter int CNT_W       = 48,
   parameter int INC_W       = 8,
   parameter int IVL_W       = 16,
   parameter int KSH_W       = 5,
   parameter int RS_W        = 16,
   parameter bit TRIG_STRICT = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   mask_en,
   input  logic                   one_err_opt,
   input  logic [IVL_W-1:0]       ivl_len,
   input  logic [KSH_W-1:0]       ratio_k,
   input  logic [IVL_W+INC_W:0]   prev_thresh,
   input  logic                   sync_ok,
   input  logic [INC_W-1:0]       zero_err_inc,
   input  logic [INC_W-1:0]       one_err_inc,
   input  logic [INC_W-1:0]       bit_inc,
   output logic [CNT_W-1:0]       tot_err,
   output logic [CNT_W-1:0]       tot_bits,
   output logic [CNT_W-1:0]       tot_zero_err,
   output logic [CNT_W-1:0]       tot_one_err,
   output logic [RS_W-1:0]        resync_cnt
);
   localparam int ACC_W = IVL_W + INC_W + 1;
   localparam int ADD_W = ACC_W + 3;
   localparam int N_TOT = 4;

   generate
      if (CNT_W < 8)  begin : g_bad_cnt  $error("CNT_W must be at least 8");  end
      if (INC_W < 1)  begin : g_bad_inc  $error("INC_W must be at least 1");  end
      if (IVL_W < 2)  begin : g_bad_ivl  $error("IVL_W must be at least 2");  end
      if (KSH_W < 1 || KSH_W > 6) begin : g_bad_ksh $error("KSH_W out of range"); end
      if (RS_W < 2)   begin : g_bad_rs   $error("RS_W must be at least 2");   end
   endgenerate

   rsm_state_e       state_q;
   logic             paused;
   logic             run;
   logic             ivl_last;
   logic [ACC_W-1:0] fin_e0, fin_e1, fin_b;
   logic [ACC_W:0]   fin_err;
   logic             trig_hit;

   logic             prev_v;
   logic [ACC_W-1:0] prev_e0, prev_e1, prev_b;
   logic [ACC_W:0]   prev_err;
   logic             prev_bad;

   logic             resync_ev;
   logic             commit_prev, commit_cur, synth;

   assign paused = (state_q == ST_PAUSE);
   assign run    = !paused && !clr;

   ber_ivl_acc #(.INC_W(INC_W), .IVL_W(IVL_W), .ACC_W(ACC_W)) u_ivl (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (clr),
      .run     (run),
      .ivl_len (ivl_len),
      .e0_inc  (zero_err_inc),
      .e1_inc  (one_err_inc),
      .b_inc   (bit_inc),
      .last    (ivl_last),
      .fin_e0  (fin_e0),
      .fin_e1  (fin_e1),
      .fin_b   (fin_b)
   );

   assign fin_err = {1'b0, fin_e0} + {1'b0, fin_e1};

   ber_ratio_trip #(.ACC_W(ACC_W), .KSH_W(KSH_W), .TRIG_STRICT(TRIG_STRICT)) u_trip (
      .err  (fin_err),
      .bits (fin_b),
      .k    (ratio_k),
      .hit  (trig_hit)
   );

   // Decision for the window that ends this cycle
   assign prev_err    = {1'b0, prev_e0} + {1'b0, prev_e1};
   assign prev_bad    = prev_err > prev_thresh;
   assign resync_ev   = ivl_last && trig_hit;
   assign commit_prev = prev_v && ivl_last && (!resync_ev || !mask_en || !prev_bad);
   assign commit_cur  = resync_ev && !mask_en;
   assign synth       = resync_ev && mask_en;

   // Holding stage for the last clean window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_v  <= 1'b0;
         prev_e0 <= '0;
         prev_e1 <= '0;
         prev_b  <= '0;
      end else if (clr) begin
         prev_v  <= 1'b0;
         prev_e0 <= '0;
         prev_e1 <= '0;
         prev_b  <= '0;
      end else if (ivl_last) begin
         if (resync_ev) begin
            prev_v <= 1'b0;
         end else begin
            prev_v  <= 1'b1;
            prev_e0 <= fin_e0;
            prev_e1 <= fin_e1;
            prev_b  <= fin_b;
         end
      end
   end

   // Run / pause sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      state_q <= ST_RUN;
      else if (clr)                    state_q <= ST_RUN;
      else if (!paused && resync_ev)   state_q <= ST_PAUSE;
      else if (paused && sync_ok)      state_q <= ST_RUN;
   end

   // Per-total increments: 0 zeros, 1 ones, 2 bits, 3 errors
   logic [ADD_W-1:0] add_v [N_TOT];
   logic [CNT_W-1:0] tot_v [N_TOT];

   assign add_v[0] = (commit_prev ? ADD_W'(prev_e0) : '0) + (commit_cur ? ADD_W'(fin_e0) : '0);
   assign add_v[1] = (commit_prev ? ADD_W'(prev_e1) : '0) + (commit_cur ? ADD_W'(fin_e1) : '0);
   assign add_v[2] = (commit_prev ? ADD_W'(prev_b)  : '0) + (commit_cur ? ADD_W'(fin_b)  : '0)
                   + ADD_W'(synth);
   assign add_v[3] = add_v[0] + add_v[1] + ADD_W'(synth && one_err_opt);

   generate
      for (genvar i = 0; i < N_TOT; i++) begin : g_tot
         ber_sat_ctr #(.CNT_W(CNT_W), .ADD_W(ADD_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .add   (add_v[i]),
            .q     (tot_v[i])
         );
      end
   endgenerate

   ber_sat_ctr #(.CNT_W(RS_W), .ADD_W(1)) u_rs_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .add   (resync_ev),
      .q     (resync_cnt)
   );

   assign tot_zero_err = tot_v[0];
   assign tot_one_err  = tot_v[1];
   assign tot_bits     = tot_v[2];
   assign tot_err      = tot_v[3];
endmodule

// File: rtl/ber_resync_accum_chk.sv
module ber_resync_accum_chk #(
   parameter int CNT_W = 48,
   parameter int RS_W  = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             in_pause,
   input logic             ivl_last,
   input logic             trig,
   input logic [CNT_W-1:0] tot_err,
   input logic [CNT_W-1:0] tot_bits,
   input logic [CNT_W-1:0] tot_e0,
   input logic [CNT_W-1:0] tot_e1,
   input logic [RS_W-1:0]  resync_cnt
);
   p_trip_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && ivl_last && trig) |=> in_pause);

   p_pause_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_pause && !clr) |=> ($stable(tot_err) && $stable(tot_bits)));

   p_resync_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr) |=> ((resync_cnt == $past(resync_cnt)) ||
                  (resync_cnt == $past(resync_cnt) + 1'b1)));

   p_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tot_err != '1) |-> (({1'b0, tot_e0} + {1'b0, tot_e1}) <= {1'b0, tot_err}));

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr) |=> (tot_bits >= $past(tot_bits)));

   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> ((tot_err == '0) && (tot_bits == '0) && (resync_cnt == '0) && !in_pause));
endmodule

bind ber_resync_accum ber_resync_accum_chk #(.CNT_W(CNT_W), .RS_W(RS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr        (clr),
   .in_pause   (paused),
   .ivl_last   (ivl_last),
   .trig       (trig_hit),
   .tot_err    (tot_err),
   .tot_bits   (tot_bits),
   .tot_e0     (tot_zero_err),
   .tot_e1     (tot_one_err),
   .resync_cnt (resync_cnt)
);

// File: tb/ber_resync_accum_bench.sv
module ber_resync_accum_bench;
   localparam int CNT_W = 48;
   localparam int SCW   = 10;
   localparam int L     = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        mask_en = 1'b1;
   logic        one_err_opt = 1'b1;
   logic [15:0] ivl_len = 16'(L);
   logic [4:0]  ratio_k = 5'd4;
   logic [24:0] prev_thresh = 25'd2;
   logic        sync_ok = 1'b0;
   logic [7:0]  zi = '0, oi = '0, bi = '0;

   logic [CNT_W-1:0] t_err, t_bits, t_e0, t_e1;
   logic [15:0]      rs;
   logic [SCW-1:0]   s_err, s_bits, s_e0, s_e1;
   logic [15:0]      s_rs;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   ber_resync_accum u_ber_resync_accum (
      .clk(clk), .rst_n(rst_n), .clr(clr), .mask_en(mask_en), .one_err_opt(one_err_opt),
      .ivl_len(ivl_len), .ratio_k(ratio_k), .prev_thresh(prev_thresh), .sync_ok(sync_ok),
      .zero_err_inc(zi), .one_err_inc(oi), .bit_inc(bi),
      .tot_err(t_err), .tot_bits(t_bits), .tot_zero_err(t_e0), .tot_one_err(t_e1),
      .resync_cnt(rs));

   ber_resync_accum #(.CNT_W(SCW)) u_ber_resync_accum_sat (
      .clk(clk), .rst_n(rst_n), .clr(clr), .mask_en(mask_en), .one_err_opt(one_err_opt),
      .ivl_len(ivl_len), .ratio_k(ratio_k), .prev_thresh(prev_thresh), .sync_ok(sync_ok),
      .zero_err_inc(zi), .one_err_inc(oi), .bit_inc(bi),
      .tot_err(s_err), .tot_bits(s_bits), .tot_zero_err(s_e0), .tot_one_err(s_e1),
      .resync_cnt(s_rs));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_all(input string tag, input logic [63:0] e, input logic [63:0] b,
                          input logic [63:0] z, input logic [63:0] o, input logic [63:0] r);
      chk({tag, " tot_err"},  64'(t_err),  e);
      chk({tag, " tot_bits"}, 64'(t_bits), b);
      chk({tag, " zeros"},    64'(t_e0),   z);
      chk({tag, " ones"},     64'(t_e1),   o);
      chk({tag, " resync"},   64'(rs),     r);
   endtask

   task automatic do_clr();
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   // One window: errors on the first cycle, 8 or more compared bits every cycle
   task automatic run_ivl(input logic [7:0] z0, input logic [7:0] o0, input logic [7:0] bper);
      for (int c = 0; c < L; c++) begin
         zi = (c == 0) ? z0 : 8'd0;
         oi = (c == 0) ? o0 : 8'd0;
         bi = bper;
         @(negedge clk);
      end
      zi = '0; oi = '0; bi = '0;
   endtask

   task automatic sync_pulse();
      sync_ok = 1'b1;
      @(negedge clk);
      sync_ok = 1'b0;
   endtask

   task automatic t_reset();
      chk_all("R11 reset", 0, 0, 0, 0, 0);
   endtask

   task automatic t_clean();
      mask_en = 1'b1; one_err_opt = 1'b1;
      do_clr();
      run_ivl(8'd1, 8'd2, 8'd8);
      chk_all("R1 held", 0, 0, 0, 0, 0);
      run_ivl(8'd0, 8'd0, 8'd8);
      chk_all("R1 commit", 3, 64, 1, 2, 0);
      run_ivl(8'd0, 8'd0, 8'd8);
      chk("R1 second commit bits", 64'(t_bits), 128);
   endtask

   task automatic t_trip_keep_prev();
      mask_en = 1'b1; one_err_opt = 1'b1;
      do_clr();
      run_ivl(8'd1, 8'd1, 8'd8);
      run_ivl(8'd3, 8'd2, 8'd8);
      chk_all("R2 R3 R6 trip keep prev", 3, 65, 1, 1, 1);
      for (int c = 0; c < 5; c++) begin
         zi = 8'd7; oi = 8'd7; bi = 8'd8;
         @(negedge clk);
      end
      zi = '0; oi = '0; bi = '0;
      chk("R4 paused err", 64'(t_err), 3);
      chk("R4 paused bits", 64'(t_bits), 65);
      sync_pulse();
      run_ivl(8'd0, 8'd0, 8'd8);
      chk("R4 after sync held", 64'(t_bits), 65);
      run_ivl(8'd0, 8'd0, 8'd8);
      chk("R4 after sync commit", 64'(t_bits), 129);
      chk("R5 one event", 64'(rs), 1);
   endtask

   task automatic t_trip_drop_prev();
      mask_en = 1'b1; one_err_opt = 1'b1;
      do_clr();
      run_ivl(8'd0, 8'd3, 8'd8);
      run_ivl(8'd3, 8'd2, 8'd8);
      chk_all("R3 R7 drop prev", 1, 1, 0, 0, 1);
      sync_pulse();
   endtask

   task automatic t_zero_opt();
      mask_en = 1'b1; one_err_opt = 1'b0;
      do_clr();
      run_ivl(8'd0, 8'd0, 8'd8);
      run_ivl(8'd4, 8'd0, 8'd8);
      chk_all("R6 zero option", 0, 65, 0, 0, 1);
      sync_pulse();
      one_err_opt = 1'b1;
   endtask

   task automatic t_mask_off();
      mask_en = 1'b0; one_err_opt = 1'b1;
      do_clr();
      run_ivl(8'd3, 8'd0, 8'd8);
      run_ivl(8'd0, 8'd5, 8'd8);
      chk_all("R8 R5 mask off", 8, 128, 3, 5, 1);
      run_ivl(8'd0, 8'd0, 8'd8);
      chk("R8 paused after trip", 64'(t_bits), 128);
      sync_pulse();
      mask_en = 1'b1;
   endtask

   task automatic t_clear();
      do_clr();
      chk_all("R10 clear", 0, 0, 0, 0, 0);
      run_ivl(8'd2, 8'd0, 8'd8);
      do_clr();
      run_ivl(8'd0, 8'd0, 8'd8);
      run_ivl(8'd0, 8'd0, 8'd8);
      chk_all("R10 held dropped", 0, 64, 0, 0, 0);
   endtask

   task automatic t_sat();
      mask_en = 1'b1;
      do_clr();
      run_ivl(8'd0, 8'd0, 8'd255);
      run_ivl(8'd0, 8'd0, 8'd255);
      chk("R9 narrow saturates", 64'(s_bits), 64'((1 << SCW) - 1));
      chk("R9 wide exact", 64'(t_bits), 2040);
      run_ivl(8'd0, 8'd0, 8'd255);
      chk("R9 stays saturated", 64'(s_bits), 64'((1 << SCW) - 1));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clean();
      t_trip_keep_prev();
      t_trip_drop_prev();
      t_zero_opt();
      t_mask_off();
      t_clear();
      t_sat();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule